// File: doc/BRIEF.md
# Hash-Slot Virtual Address Rebuilder

This block recovers the virtual address that a hashed page-table entry maps. The entry itself does not hold that address. It holds an abbreviated page number, and the remaining page-index bits are implied by where the entry sits in the table. The block receives three things on the same cycle:

- the entry's 64-bit first word;
- the entry's slot index within the table;
- the hash mask currently programmed for that table.

The block undoes the placement hash in three steps. It divides the slot by the group size to get a group number. It complements that group number when the entry was placed with the secondary hash. It then XOR-folds the group number with segment bits taken from the coarse address and masks the result. That result is merged back into the coarse address. Entries for large pages skip this step and return the coarse address alone.

The datapath is combinational and ends in a single output register, so a result appears one clock after its request. The entry's own valid bit plays no part in the address. It is carried to a separate output flag so that downstream logic can discard empty slots. Reset is synchronous.

Top module: `hslot_va_rebuild`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: While `rst` is high at a clock edge, `out_valid`, `out_vaddr` and `out_entry_valid` are zero after that edge.
- R3: The coarse address is entry bits 63:7 shifted left by 23 and truncated to 64 bits. This places entry bits 47:7 at address bits 63:23, with zeros below. Entry bits 63:48 are lost.
- R4: When entry bit 2 (large page) is 1, `out_vaddr` equals the coarse address, whatever the slot and mask are.
- R5: When entry bit 2 is 0 and bit 1 (secondary) is 0, `out_vaddr` is the coarse address ORed with the page index shifted left by PAGE_SHIFT (default 12). The page index is ((coarse >> 28) XOR (slot >> 3)) AND mask, where the slot is zero-extended to 64 bits. Each group holds 8 entries.
- R6: When entry bit 2 is 0 and bit 1 is 1, the 64-bit group number (slot >> 3) is bitwise complemented before the XOR of R5.
- R7: Entry bit 0 (valid) has no effect on `out_vaddr` and appears on `out_entry_valid` one cycle later.
- R8: Entry bits 6:3, which include bolted (bit 4) and lock (bit 3), have no effect on `out_vaddr`.
- R9: `out_vaddr` and `out_entry_valid` only change on a cycle with `in_valid` high. Otherwise they hold their last value.
- R10: The slot and mask are taken from the same cycle as the entry word. Back-to-back requests that use different masks each yield their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request qualifier |
| pte_word | input | 64 | First word of the page-table entry |
| slot_idx | input | SLOT_W | Slot index of the entry in the table |
| hash_mask | input | 64 | Hash mask of the table |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_vaddr | output | 64 | Rebuilt virtual address |
| out_entry_valid | output | 1 | Entry valid bit, carried through |

## Verification
Every result is due exactly one clock after its request, because there is a single register between the inputs and the outputs. The driver presents each request at a falling edge and queues the value expected for it. The monitor samples at the next falling edge on which `out_valid` is high and pops the queue in order, so back-to-back requests are matched one to one. Hold and reset behaviour is sampled at the falling edge that follows the edge concerned.

// File: rtl/hslot_va_rebuild.sv
module hslot_va_rebuild #(
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       pte_word,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [63:0]       hash_mask,
  output logic              out_valid,
  output logic [63:0]       out_vaddr,
  output logic              out_entry_valid
);
  localparam int GROUP_LOG2 = 3;

  logic [63:0] coarse, group, group_sel, page_idx, va_next;
  logic        is_large, is_second;

  assign is_large  = pte_word[2];
  assign is_second = pte_word[1];
  assign coarse    = {pte_word[47:7], 23'b0};
  assign group     = 64'(slot_idx) >> GROUP_LOG2;
  assign group_sel = is_second ? ~group : group;
  assign page_idx  = ((coarse >> 28) ^ group_sel) & hash_mask;
  assign va_next   = is_large ? coarse : (coarse | (page_idx << PAGE_SHIFT));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_vaddr       <= '0;
      out_entry_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vaddr       <= va_next;
        out_entry_valid <= pte_word[0];
      end
    end
  end
endmodule

module hslot_va_rebuild_chk #(
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_W     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [63:0]       pte_word,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [63:0]       hash_mask,
  input logic              out_valid,
  input logic [63:0]       out_vaddr,
  input logic              out_entry_valid
);
  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vaddr == 64'd0 && !out_entry_valid));
  assert_large_coarse_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pte_word[2]) |=> out_vaddr == {$past(pte_word[47:7]), 23'b0});
  assert_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_vaddr[PAGE_SHIFT-1:0] == '0);
  assert_flag_pass_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_entry_valid == $past(pte_word[0]));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_vaddr) && $stable(out_entry_valid)));
endmodule

bind hslot_va_rebuild hslot_va_rebuild_chk #(.PAGE_SHIFT(PAGE_SHIFT), .SLOT_W(SLOT_W)) chk_i (.*);

// File: tb/hslot_va_rebuild_tb_top.sv
module hslot_va_rebuild_tb_top;
  localparam int PS = 12;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [63:0]   pte_word = '0;
  logic [SW-1:0] slot_idx = '0;
  logic [63:0]   hash_mask = '0;
  logic          out_valid, out_entry_valid;
  logic [63:0]   out_vaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];
  logic [64:0] last_exp = '0;

  hslot_va_rebuild #(.PAGE_SHIFT(PS), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pte_word(pte_word),
    .slot_idx(slot_idx), .hash_mask(hash_mask), .out_valid(out_valid),
    .out_vaddr(out_vaddr), .out_entry_valid(out_entry_valid));

  always #10 clk = ~clk;

  function automatic logic [63:0] model(logic [63:0] w, logic [SW-1:0] s, logic [63:0] m);
    logic [63:0] c, g, v;
    c = w[63:7] << 23;
    if (w[2]) return c;
    g = {32'd0, s} / 64'd8;
    if (w[1]) g = ~g;
    v = ((c >> 28) ^ g) & m;
    return c | (v << PS);
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [63:0] w, logic [SW-1:0] s, logic [63:0] m, string req);
    @(negedge clk);
    in_valid = 1'b1; pte_word = w; slot_idx = s; hash_mask = m;
    exp_q.push_back({w[0], model(w, s, m)});
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      pte_word = 64'hDEAD_BEEF_0BAD_F00D ^ 64'(i);
      slot_idx = SW'(32'h5A5A_0000 + i);
      hash_mask = '1;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected out_valid", 65'd1, 65'd0);
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), {out_entry_valid, out_vaddr}, last_exp);
      end
    end
  end

  initial begin
    in_valid = 1'b1; pte_word = '1; slot_idx = '1; hash_mask = '1;
    repeat (3) @(negedge clk);
    check("R2 reset outputs", {out_valid, out_entry_valid, out_vaddr}, 66'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1 idle low", {64'd0, out_valid}, 65'd0);

    send(64'h0123_4567_89AB_CD01, 32'd10, 64'h0000_0000_0007_FFFF, "R5 primary small");
    send(64'h0123_4567_89AB_CD03, 32'd10, 64'h0000_0000_0007_FFFF, "R6 secondary small");
    send(64'hFFFF_8000_0000_0085, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 R4 large truncation");
    send(64'h7654_3210_FEDC_BA07, 32'd77, 64'h0000_0000_0000_0FFF, "R4 large secondary");
    send(64'h0000_1234_5678_9A00, 32'd1000, 64'h0000_0000_0000_FFFF, "R7 valid clear");
    send(64'h0000_1234_5678_9A01, 32'd1000, 64'h0000_0000_0000_FFFF, "R7 valid set");
    send(64'h0000_1234_5678_9A79, 32'd1000, 64'h0000_0000_0000_FFFF, "R8 bolted lock set");
    send(64'hABCD_0000_1111_2201, 32'd4096, 64'd0, "R5 zero mask");
    send(64'hABCD_0000_1111_2203, 32'hFFFF_FFF8, 64'h0000_0000_00FF_FFFF, "R6 top slot secondary");
    send(64'h0F0F_F0F0_0F0F_F081, 32'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R5 full mask slot 7");
    send(64'h0F0F_F0F0_0F0F_F081, 32'd8, 64'h0000_0000_0000_0003, "R10 mask a");
    send(64'h0F0F_F0F0_0F0F_F081, 32'd8, 64'h0000_0000_0000_00F0, "R10 mask b");
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);
    idle(3);
    check("R9 hold while idle", {out_entry_valid, out_vaddr}, last_exp);
    check("R1 valid low after idle", {64'd0, out_valid}, 65'd0);

    send(64'h1111_2222_3333_4403, 32'd123456, 64'h0000_0000_0003_FFFF, "R6 after idle");
    idle(1);
    while (exp_q.size() != 0) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule